// File: doc/BRIEF.md
# Serial 8x8 Two-Dimensional DCT

This block computes an unscaled two-dimensional discrete cosine transform over an 8x8 tile of 8-bit grey pixels. Pixels enter one per enabled clock in raster order. A row pass forms eight 1-D cosine sums for each row as the row streams in. The row results are parked in a 64-word transpose store. A column pass then walks that store column by column and forms the eight column sums. The 64 coefficients leave one per enabled clock, each tagged by a valid flag.

The basis weights are 256*cos((2n+1)k*pi/16), rounded to the nearest integer. Products are kept at full precision. The result is cut down once, at the output, to a signed fixed-point word with 8 fractional bits. The normalisation factors of the transform are not applied, so a downstream quantizer can fold them into its own per-coefficient scale. `en_i` acts as a clock enable for the entire datapath. A block takes 128 enabled cycles: 64 to load pixels and 64 for the column pass. The last column's coefficients drain while the next block loads.

Top module: `dct2d_serial`

## Requirements
- R1: While `rst_ni` is low, `valid_o` is 0 and `coef_o` is 0, asynchronously and independent of the clock.
- R2: After reset, the first enabled cycle takes pixel x(0,0). The next 63 enabled cycles take the rest of the tile in raster order, where pixel n of row m arrives at enabled cycle 8m+n.
- R3: Row sum R(m,k) = sum over n of x(m,n)*c(k,n), where c(k,n) = round(256*cos((2n+1)k*pi/16)), with no rounding of intermediate values.
- R4: Raw column sum S(p,q) = sum over m of R(m,q)*c(p,m). The output word is floor(S/256): a two's-complement value with 8 fractional bits.
- R5: An output value above 2^21-1 is clamped to 2^21-1, and one below -2^21 is clamped to -2^21.
- R6: Coefficients leave in column-major order. Output index i = 8q+p carries Y(p,q).
- R7: Output index i of a block appears after enabled edge 72+i, counting the first pixel's edge as 1. `valid_o` stays high for exactly 64 consecutive enabled cycles per block.
- R8: During the 64 enabled cycles that follow a block's last pixel, `pix_i` is ignored. The next block's first pixel is taken on enabled edge 129.
- R9: When `en_i` is low on an edge, nothing advances: `coef_o` and `valid_o` hold, and `pix_i` is not taken.
- R10: Asserting `rst_ni` in the middle of a block abandons that block. After release, the next enabled cycle starts a fresh tile as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable for the whole datapath |
| pix_i | input | 8 | Unsigned pixel, raster order |
| coef_o | output | 22 | Signed coefficient, 8 fractional bits |
| valid_o | output | 1 | High while a coefficient is on `coef_o` |

## Verification
Every result is due at a cycle fixed by the count of enabled edges since reset. Coefficient i of block b is due after enabled edge 128b+72+i. The bench counts enabled edges on its own and samples at the falling edge. At that point it derives both the expected `valid_o` and the coefficient index, so randomly placed enable gaps move the schedule without desynchronising it. On each edge where `en_i` was low, the bench also checks that both outputs repeat their previous sample.

// File: rtl/dct2d_pkg.sv
package dct2d_pkg;
  localparam int unsigned BLK_N = 8;
  localparam int unsigned IDX_W = $clog2(BLK_N);
  localparam int unsigned CFRAC = 8;
  localparam int unsigned CW    = CFRAC + 2;

  typedef logic signed [CW-1:0] coef_t;

  // round(256*cos(j*pi/16)), j = 0..7
  localparam coef_t MAG_TBL [BLK_N] = '{
    10'sd256, 10'sd251, 10'sd237, 10'sd213,
    10'sd181, 10'sd142, 10'sd98,  10'sd50
  };

  // c(k,n) = round(256*cos((2n+1)k*pi/16)) by folding the angle into one quadrant
  function automatic coef_t basis(input int unsigned k, input logic [IDX_W-1:0] n);
    logic [4:0] a;
    a = 5'((32'(n) * 2 + 1) * k);
    if (a == 5'd8 || a == 5'd24) return '0;
    if (a < 5'd8)  return MAG_TBL[a[2:0]];
    if (a < 5'd16) return -MAG_TBL[3'(3'd0 - a[2:0])];
    if (a < 5'd24) return -MAG_TBL[a[2:0]];
    return MAG_TBL[3'(3'd0 - a[2:0])];
  endfunction
endpackage

// File: rtl/dct2d_ctrl.sv
module dct2d_ctrl
  import dct2d_pkg::*;
#(
  parameter int unsigned CNT_W = 2 * IDX_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             col_ph_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             ph_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else if (en_i) begin
      cnt_q <= cnt_q + CNT_W'(1);
      if (cnt_q == '1) ph_q <= ~ph_q;
    end
  end

  assign cnt_o    = cnt_q;
  assign col_ph_o = ph_q;

  // R8
  phase_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != $past(ph_q)) |-> ($past(cnt_q) == '1 && $past(en_i)));
endmodule

// File: rtl/dct2d_mac.sv
module dct2d_mac
  import dct2d_pkg::*;
#(
  parameter int unsigned IN_W  = 9,
  parameter int unsigned ACC_W = IN_W + CW + IDX_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    first_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic signed [IN_W-1:0]  samp_i,
  output logic signed [ACC_W-1:0] sum_o [BLK_N]
);
  for (genvar k = 0; k < BLK_N; k++) begin : g_lane
    coef_t                   c;
    logic signed [ACC_W-1:0] prod;
    logic signed [ACC_W-1:0] base;
    logic signed [ACC_W-1:0] acc_q;

    assign c        = basis(k, idx_i);
    assign prod     = ACC_W'(samp_i) * ACC_W'(c);
    assign base     = first_i ? '0 : acc_q;
    assign sum_o[k] = base + prod;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   acc_q <= '0;
      else if (en_i) acc_q <= sum_o[k];
    end
  end
endmodule

// File: rtl/dct2d_tbuf.sv
module dct2d_tbuf
  import dct2d_pkg::*;
#(
  parameter int unsigned W = 22
) (
  input  logic                clk_i,
  input  logic                we_i,
  input  logic [IDX_W-1:0]    wrow_i,
  input  logic signed [W-1:0] wdata_i [BLK_N],
  input  logic [IDX_W-1:0]    rrow_i,
  input  logic [IDX_W-1:0]    rcol_i,
  output logic signed [W-1:0] rdata_o
);
  logic signed [W-1:0] mem [BLK_N][BLK_N];

  // always written before it is read, so no reset
  always_ff @(posedge clk_i) begin
    if (we_i) begin
      for (int c = 0; c < BLK_N; c++) mem[wrow_i][c] <= wdata_i[c];
    end
  end

  assign rdata_o = mem[rrow_i][rcol_i];
endmodule

// File: rtl/dct2d_out.sv
module dct2d_out
  import dct2d_pkg::*;
#(
  parameter int unsigned IN_W  = 35,
  parameter int unsigned OUT_W = 22,
  parameter int unsigned SHIFT = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic                    load_i,
  input  logic signed [IN_W-1:0]  res_i [BLK_N],
  output logic signed [OUT_W-1:0] dout_o,
  output logic                    valid_o
);
  localparam int unsigned TW = IN_W - SHIFT;
  localparam logic signed [TW-1:0] MAX_T = TW'((64'sd1 <<< (OUT_W - 1)) - 64'sd1);
  localparam logic signed [TW-1:0] MIN_T = TW'(-(64'sd1 <<< (OUT_W - 1)));

  logic signed [TW-1:0]    tr  [BLK_N];
  logic signed [OUT_W-1:0] sat [BLK_N];
  logic signed [OUT_W-1:0] sh_q [BLK_N];
  logic [IDX_W:0]          left_q;

  for (genvar p = 0; p < BLK_N; p++) begin : g_sat
    assign tr[p]  = TW'(res_i[p] >>> SHIFT);
    assign sat[p] = (tr[p] > MAX_T) ? OUT_W'(MAX_T) :
                    (tr[p] < MIN_T) ? OUT_W'(MIN_T) : OUT_W'(tr[p]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BLK_N; i++) sh_q[i] <= '0;
      left_q <= '0;
    end else if (en_i) begin
      if (load_i) begin
        for (int i = 0; i < BLK_N; i++) sh_q[i] <= sat[i];
        left_q <= (IDX_W + 1)'(BLK_N);
      end else begin
        for (int i = 0; i < BLK_N - 1; i++) sh_q[i] <= sh_q[i+1];
        sh_q[BLK_N-1] <= '0;
        if (left_q != '0) left_q <= left_q - 1'b1;
      end
    end
  end

  assign dout_o  = sh_q[0];
  assign valid_o = (left_q != '0);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> ($stable(dout_o) && $stable(valid_o)));

  // R5
  clamp_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && load_i && tr[0] > MAX_T) |=> (dout_o == OUT_W'(MAX_T)));
endmodule

// File: rtl/dct2d_serial.sv
module dct2d_serial
  import dct2d_pkg::*;
#(
  parameter int unsigned PIX_W    = 8,
  parameter int unsigned OUT_W    = 22,
  parameter int unsigned OUT_FRAC = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    en_i,
  input  logic [PIX_W-1:0]        pix_i,
  output logic signed [OUT_W-1:0] coef_o,
  output logic                    valid_o
);
  localparam int unsigned CNT_W    = 2 * IDX_W;
  localparam int unsigned ROW_IN_W = PIX_W + 1;
  localparam int unsigned ROW_W    = ROW_IN_W + CW + IDX_W;
  localparam int unsigned COL_W    = ROW_W + CW + IDX_W;
  localparam int unsigned SHIFT    = 2 * CFRAC - OUT_FRAC;

  logic [CNT_W-1:0]        cnt;
  logic                    col_ph;
  logic [IDX_W-1:0]        pos;
  logic [IDX_W-1:0]        grp;
  logic                    lane_last;
  logic signed [ROW_IN_W-1:0] pix_s;
  logic signed [ROW_W-1:0] row_sum [BLK_N];
  logic signed [ROW_W-1:0] tb_rd;
  logic signed [COL_W-1:0] col_sum [BLK_N];

  dct2d_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_i),
    .cnt_o    (cnt),
    .col_ph_o (col_ph)
  );

  assign pos       = cnt[IDX_W-1:0];
  assign grp       = cnt[CNT_W-1:IDX_W];
  assign lane_last = (pos == '1);
  assign pix_s     = $signed({1'b0, pix_i});

  dct2d_mac #(.IN_W(ROW_IN_W), .ACC_W(ROW_W)) u_row (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i & ~col_ph),
    .first_i (pos == '0),
    .idx_i   (pos),
    .samp_i  (pix_s),
    .sum_o   (row_sum)
  );

  dct2d_tbuf #(.W(ROW_W)) u_tbuf (
    .clk_i   (clk_i),
    .we_i    (en_i & ~col_ph & lane_last),
    .wrow_i  (grp),
    .wdata_i (row_sum),
    .rrow_i  (pos),
    .rcol_i  (grp),
    .rdata_o (tb_rd)
  );

  dct2d_mac #(.IN_W(ROW_W), .ACC_W(COL_W)) u_col (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i & col_ph),
    .first_i (pos == '0),
    .idx_i   (pos),
    .samp_i  (tb_rd),
    .sum_o   (col_sum)
  );

  dct2d_out #(.IN_W(COL_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .load_i  (col_ph & lane_last),
    .res_i   (col_sum),
    .dout_o  (coef_o),
    .valid_o (valid_o)
  );

  // R7
  valid_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> !col_ph);

  // R7
  valid_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (col_ph && cnt == CNT_W'(BLK_N)));
endmodule

// File: tb/sim_dct2d_serial.sv
module sim_dct2d_serial;
  localparam int MAXB = 64;
  localparam longint OMAX = 64'sd2097151;
  localparam longint OMIN = -64'sd2097152;

  logic clk = 1'b0;
  logic rst_n = 1'b1;
  logic en = 1'b0;
  logic [7:0] pix = '0;
  logic signed [21:0] dout;
  logic valid;

  always #5 clk = ~clk;

  dct2d_serial u0 (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .en_i    (en),
    .pix_i   (pix),
    .coef_o  (dout),
    .valid_o (valid)
  );

  int n_chk = 0;
  int n_bad = 0;
  int e = 0;
  bit last_en = 0;
  bit finished = 0;
  int mpos, mblk;
  int blkpix [MAXB][64];
  int expv   [MAXB][64];
  logic signed [21:0] prev_dout;
  logic prev_valid;

  function automatic int cq(int k, int n);
    return int'(256.0 * $cos(real'((2 * n + 1) * k) * 3.14159265358979 / 16.0));
  endfunction

  function automatic void make_ref(int b);
    longint rr [8][8];
    longint s, y;
    for (int m = 0; m < 8; m++)
      for (int k = 0; k < 8; k++) begin
        rr[m][k] = 0;
        for (int n = 0; n < 8; n++) rr[m][k] += longint'(blkpix[b][8*m+n]) * cq(k, n);
      end
    for (int q = 0; q < 8; q++)
      for (int p = 0; p < 8; p++) begin
        s = 0;
        for (int m = 0; m < 8; m++) s += rr[m][q] * cq(p, m);
        y = s >>> 8;
        if (y > OMAX) y = OMAX;
        if (y < OMIN) y = OMIN;
        expv[b][8*q+p] = int'(y);
      end
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // own model of accepted pixels, by enabled-edge count
  always @(posedge clk) begin
    last_en = en;
    if (rst_n && en) begin
      mpos = e % 128;
      mblk = e / 128;
      if (mpos < 64 && mblk < MAXB) begin
        blkpix[mblk][mpos] = int'(pix);
        if (mpos == 63) make_ref(mblk);
      end
      e++;
    end
  end

  always @(negedge clk) begin
    int r;
    bit ev;
    if (rst_n && !finished) begin
      r  = e - 72;
      ev = (r >= 0) && ((r % 128) < 64) && ((r / 128) < MAXB);
      check("R7 valid schedule", int'(valid), int'(ev));
      if (ev && valid)
        check("R2 R3 R4 R5 R6 R8 coefficient", int'(dout), expv[r/128][r%128]);
      if (!last_en && e > 0) begin
        check("R9 coef hold", int'(dout), int'(prev_dout));
        check("R9 valid hold", int'(valid), int'(prev_valid));
      end
      prev_dout  = dout;
      prev_valid = valid;
    end
  end

  task automatic tick(input logic [7:0] v, input bit may_pause);
    if (may_pause && ($urandom % 7 == 0)) begin
      en  = 1'b0;
      pix = 8'($urandom);
      @(negedge clk);
    end
    en  = 1'b1;
    pix = v;
    @(negedge clk);
  endtask

  task automatic do_block(input int kind, input bit may_pause);
    logic [7:0] v;
    for (int i = 0; i < 64; i++) begin
      case (kind)
        1: v = 8'd0;
        2: v = 8'd255;                                       // R5 upper clamp on Y(0,0)
        3: v = (((i / 8) + (i % 8)) % 2 == 1) ? 8'd255 : 8'd0;
        4: v = 8'((i % 8) * 36);
        5: v = ((i / 8) < 4) ? 8'd255 : 8'd0;
        6: v = 8'($urandom % 16);
        default: v = 8'($urandom);
      endcase
      tick(v, may_pause);
    end
    // R8: column-pass cycles, pixels here must have no effect
    for (int i = 0; i < 64; i++) tick(8'($urandom), may_pause);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 reset valid", int'(valid), 0);
    check("R1 reset coef", int'(dout), 0);
    #2 rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 1; k <= 6; k++) do_block(k, 1'b0);
    for (int k = 0; k < 8; k++) do_block(0, 1'b1);
    // R10: reset while the previous block is still draining
    for (int i = 0; i < 5; i++) tick(8'($urandom), 1'b0);
    #2 rst_n = 1'b0;
    #1;
    check("R10 mid-block reset valid", int'(valid), 0);
    check("R10 mid-block reset coef", int'(dout), 0);
    e = 0;
    last_en = 0;
    @(negedge clk);
    #2 rst_n = 1'b1;
    do_block(0, 1'b1);
    do_block(2, 1'b0);
    for (int i = 0; i < 80; i++) tick(8'($urandom), 1'b0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule